// File: doc/BRIEF.md
# Utility Monitor Way Partitioner

This block watches the access stream of a 16-way last-level cache that two cores share and decides how many ways each core should own. Every access carries a valid flag, a core id, a set index and a tag. For each core the block keeps a shadow tag directory that models true LRU on a sampled subset of the sets: only sets whose index has its low `SAMPLE_LOG2` bits at zero. For every recency position, from MRU (0) to LRU (15), it counts how often that core hit there. Because LRU is a stack algorithm, the hits a core would see with `a` ways are the sum of its first `a` position counters.

A free-running timer starts a repartition every `INTERVAL` cycles, nominally five million. The search tries one candidate split per cycle, with core 0 taking `a` ways and core 1 taking `16 - a` ways for `a` from 1 to 15. It keeps the split with the largest combined hit count, and the smaller `a` wins a tie. When the last candidate has been scored, the block presents the result on `ways_core0` and raises `partition_valid` for one cycle. On that same edge every hit counter in both monitors is halved, so older behaviour still counts but at half weight. Hits are not counted while a search is running. The shadow tag directories keep tracking accesses during that time.

The replacement logic that enforces the split in the real cache is outside this block. So is the data array.

Top module: `umon_way_partitioner`

## Requirements
- R1: While reset is held and after it is released, `ways_core0` is 8 and `partition_valid` is 0 until the first result is ready.
- R2: Counting rising edges after reset release from 1, `partition_valid` is high for exactly one cycle after edge `INTERVAL + 15 + m*INTERVAL` for result m = 0, 1, 2, and so on. It is low at every other time.
- R3: An access whose set index has any of its low `SAMPLE_LOG2` bits (default 5, so every 32nd set is sampled) set to one leaves both monitors unchanged.
- R4: Each core has its own LRU directory with positions 0 (MRU) to 15 (LRU). An access that finds its tag at position p adds one to that core's counter p. Cycling through k fresh distinct tags in one sampled set gives k misses, and after that every access hits at position k-1, even when the other core's accesses are interleaved in the same set.
- R5: The result is the `a` in 1..15 that maximises (sum of core 0 counters 0..a-1) + (sum of core 1 counters 0..15-a). `ways_core0` never leaves the range 1 to 15.
- R6: When several splits reach the same maximum total, including when all counters are zero, the smallest `a` is chosen.
- R7: On the edge that produces each result, every hit counter of both cores is replaced by half its value, rounded down.
- R8: A hit counter at its maximum, 2^`CNT_W` - 1, stays there on further hits and does not wrap.
- R9: `ways_core0` changes only on the edge that raises `partition_valid`. It holds its value in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | An access is present this cycle |
| acc_core | input | 1 | Core issuing the access (0 or 1) |
| acc_set | input | SET_W | Set index of the access |
| acc_tag | input | TAG_W | Tag of the access |
| ways_core0 | output | 5 | Ways granted to core 0; core 1 gets 16 minus this |
| partition_valid | output | 1 | One-cycle pulse when a new split is presented |

## Verification
An access changes a monitor on the rising edge where it is presented, so a hit counted in one cycle can affect the next search. The split itself appears 15 edges after the edge at which the interval timer expires. The bench records which edge each pulse follows and compares that number to the R2 formula. It reads the split and the one-cycle shape of the pulse at falling edges, just after the pulse rises and one cycle later. All stimulus for an interval fits between one result and the next timer expiry, so no access falls inside a search window. The expected split comes from a model of the counters kept in the bench, which applies saturation on each hit and halving at each result.

// File: rtl/umon_pkg.sv
package umon_pkg;

    localparam int LLC_WAYS = 16;
    localparam int POS_W    = 4;
    localparam int SPLIT_W  = 5;

    localparam logic [SPLIT_W-1:0] SPLIT_MIN   = 5'd1;
    localparam logic [SPLIT_W-1:0] SPLIT_MAX   = 5'd15;
    localparam logic [SPLIT_W-1:0] SPLIT_RESET = 5'd8;

    typedef enum logic {
        SRCH_IDLE,
        SRCH_SCAN
    } srch_state_e;

    typedef struct packed {
        logic             hit;
        logic [POS_W-1:0] pos;
    } lookup_t;

    // ways left for core 1 when core 0 holds a ways
    function automatic logic [SPLIT_W-1:0] other_ways(input logic [SPLIT_W-1:0] a);
        return SPLIT_W'(LLC_WAYS) - a;
    endfunction

endpackage

// File: rtl/umon_interval_timer.sv
module umon_interval_timer #(
    parameter int INTERVAL = 5000000
) (
    input  logic clk,
    input  logic rst,
    output logic start_o
);
    localparam int CW = (INTERVAL > 2) ? $clog2(INTERVAL) : 1;
    localparam logic [CW-1:0] LAST = CW'(INTERVAL - 1);

    logic [CW-1:0] cnt_q;

    assign start_o = (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (rst)          cnt_q <= '0;
        else if (start_o) cnt_q <= '0;
        else              cnt_q <= cnt_q + 1'b1;
    end

    p_start_single_r2: assert property (@(posedge clk) disable iff (rst)
        start_o |=> !start_o);

endmodule

// File: rtl/umon_atd.sv
module umon_atd
    import umon_pkg::*;
#(
    parameter int SET_W       = 10,
    parameter int TAG_W       = 16,
    parameter int SAMPLE_LOG2 = 5,
    parameter int CNT_W       = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      acc_v,
    input  logic [SET_W-1:0]          acc_set,
    input  logic [TAG_W-1:0]          acc_tag,
    input  logic                      freeze,
    input  logic                      age,
    output logic [LLC_WAYS*CNT_W-1:0] hits_flat
);
    localparam int SIDX_W = SET_W - SAMPLE_LOG2;
    localparam int NSETS  = 1 << SIDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [TAG_W-1:0]    tag_q  [NSETS][LLC_WAYS];
    logic [LLC_WAYS-1:0] vld_q  [NSETS];
    logic [CNT_W-1:0]    hcnt_q [LLC_WAYS];

    logic              sampled;
    logic              upd;
    logic [SIDX_W-1:0] sidx;
    lookup_t           lk;
    logic [POS_W-1:0]  shift_lim;

    assign sampled   = (acc_set[SAMPLE_LOG2-1:0] == '0);
    assign sidx      = acc_set[SET_W-1:SAMPLE_LOG2];
    assign upd       = acc_v && sampled;
    assign shift_lim = lk.hit ? lk.pos : POS_W'(LLC_WAYS - 1);

    // recency lookup: position of the matching tag in the sampled set
    always_comb begin
        lk = '0;
        for (int w = LLC_WAYS - 1; w >= 0; w--) begin
            if (vld_q[sidx][w] && (tag_q[sidx][w] == acc_tag)) begin
                lk.hit = 1'b1;
                lk.pos = POS_W'(w);
            end
        end
    end

    // move the accessed tag to MRU, push older entries one step down
    always_ff @(posedge clk) begin
        if (upd) begin
            tag_q[sidx][0] <= acc_tag;
            for (int w = 1; w < LLC_WAYS; w++) begin
                if (POS_W'(w) <= shift_lim) tag_q[sidx][w] <= tag_q[sidx][w-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NSETS; s++) vld_q[s] <= '0;
        end else if (upd) begin
            vld_q[sidx][0] <= 1'b1;
            for (int w = 1; w < LLC_WAYS; w++) begin
                if (POS_W'(w) <= shift_lim) vld_q[sidx][w] <= vld_q[sidx][w-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int w = 0; w < LLC_WAYS; w++) hcnt_q[w] <= '0;
        end else if (age) begin
            for (int w = 0; w < LLC_WAYS; w++) hcnt_q[w] <= hcnt_q[w] >> 1;
        end else if (upd && lk.hit && !freeze && (hcnt_q[lk.pos] != CNT_MAX)) begin
            hcnt_q[lk.pos] <= hcnt_q[lk.pos] + 1'b1;
        end
    end

    for (genvar g = 0; g < LLC_WAYS; g++) begin : g_cnt
        assign hits_flat[g*CNT_W +: CNT_W] = hcnt_q[g];

        p_no_wrap_r8: assert property (@(posedge clk) disable iff (rst)
            !age |=> (hcnt_q[g] >= $past(hcnt_q[g])));

        p_age_shrinks_r7: assert property (@(posedge clk) disable iff (rst)
            age |=> (hcnt_q[g] <= $past(hcnt_q[g])));

        p_unsampled_quiet_r3: assert property (@(posedge clk) disable iff (rst)
            (acc_v && !sampled && !age) |=> $stable(hcnt_q[g]));
    end

endmodule

// File: rtl/umon_split_search.sv
module umon_split_search
    import umon_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start_i,
    input  logic [LLC_WAYS*CNT_W-1:0] hits0_flat,
    input  logic [LLC_WAYS*CNT_W-1:0] hits1_flat,
    output logic                      busy_o,
    output logic                      age_o,
    output logic [SPLIT_W-1:0]        ways_o,
    output logic                      valid_o
);
    localparam int SUM_W = CNT_W + POS_W + 2;

    srch_state_e        state_q;
    logic [SPLIT_W-1:0] cand_q;
    logic [SPLIT_W-1:0] best_a_q;
    logic [SUM_W-1:0]   best_sum_q;
    logic [SUM_W-1:0]   cand_total;
    logic [SPLIT_W-1:0] cand_other;
    logic               better;

    assign cand_other = other_ways(cand_q);
    assign busy_o     = (state_q == SRCH_SCAN);
    assign age_o      = busy_o && (cand_q == SPLIT_MAX);
    assign better     = (cand_total > best_sum_q);

    // prefix sums for the current candidate split
    always_comb begin
        cand_total = '0;
        for (int i = 0; i < LLC_WAYS; i++) begin
            if (SPLIT_W'(i) < cand_q)
                cand_total = cand_total + SUM_W'(hits0_flat[i*CNT_W +: CNT_W]);
            if (SPLIT_W'(i) < cand_other)
                cand_total = cand_total + SUM_W'(hits1_flat[i*CNT_W +: CNT_W]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SRCH_IDLE;
            cand_q     <= SPLIT_MIN;
            best_a_q   <= SPLIT_MIN;
            best_sum_q <= '0;
            ways_o     <= SPLIT_RESET;
            valid_o    <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            case (state_q)
                SRCH_IDLE: begin
                    if (start_i) begin
                        state_q    <= SRCH_SCAN;
                        cand_q     <= SPLIT_MIN;
                        best_a_q   <= SPLIT_MIN;
                        best_sum_q <= '0;
                    end
                end
                SRCH_SCAN: begin
                    if (better) begin
                        best_a_q   <= cand_q;
                        best_sum_q <= cand_total;
                    end
                    if (cand_q == SPLIT_MAX) begin
                        state_q <= SRCH_IDLE;
                        ways_o  <= better ? cand_q : best_a_q;
                        valid_o <= 1'b1;
                    end else begin
                        cand_q <= cand_q + 1'b1;
                    end
                end
                default: state_q <= SRCH_IDLE;
            endcase
        end
    end

    p_valid_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    p_ways_bounds_r5: assert property (@(posedge clk) disable iff (rst)
        (ways_o >= SPLIT_MIN) && (ways_o <= SPLIT_MAX));

    p_cand_bounds_r5: assert property (@(posedge clk) disable iff (rst)
        busy_o |-> ((cand_q >= SPLIT_MIN) && (cand_q <= SPLIT_MAX)));

    p_ways_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(ways_o) |-> valid_o);

endmodule

// File: rtl/umon_way_partitioner.sv
module umon_way_partitioner
    import umon_pkg::*;
#(
    parameter int SET_W       = 10,
    parameter int TAG_W       = 16,
    parameter int SAMPLE_LOG2 = 5,
    parameter int CNT_W       = 16,
    parameter int INTERVAL    = 5000000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               acc_valid,
    input  logic               acc_core,
    input  logic [SET_W-1:0]   acc_set,
    input  logic [TAG_W-1:0]   acc_tag,
    output logic [SPLIT_W-1:0] ways_core0,
    output logic               partition_valid
);
    localparam int NCORES = 2;

    logic                      start;
    logic                      busy;
    logic                      age;
    logic [LLC_WAYS*CNT_W-1:0] hits_flat [NCORES];

    umon_interval_timer #(
        .INTERVAL (INTERVAL)
    ) timer_i (
        .clk     (clk),
        .rst     (rst),
        .start_o (start)
    );

    for (genvar c = 0; c < NCORES; c++) begin : g_mon
        umon_atd #(
            .SET_W       (SET_W),
            .TAG_W       (TAG_W),
            .SAMPLE_LOG2 (SAMPLE_LOG2),
            .CNT_W       (CNT_W)
        ) atd_i (
            .clk       (clk),
            .rst       (rst),
            .acc_v     (acc_valid && (acc_core == 1'(c))),
            .acc_set   (acc_set),
            .acc_tag   (acc_tag),
            .freeze    (busy),
            .age       (age),
            .hits_flat (hits_flat[c])
        );
    end

    umon_split_search #(
        .CNT_W (CNT_W)
    ) search_i (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start),
        .hits0_flat (hits_flat[0]),
        .hits1_flat (hits_flat[1]),
        .busy_o     (busy),
        .age_o      (age),
        .ways_o     (ways_core0),
        .valid_o    (partition_valid)
    );

    p_start_idle_r2: assert property (@(posedge clk) disable iff (rst)
        partition_valid |-> !start);

endmodule

// File: tb/umon_way_partitioner_tb.sv
module umon_way_partitioner_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int P_SET_W    = 8;
    localparam int P_TAG_W    = 10;
    localparam int P_SAMPLE   = 5;
    localparam int P_CNT_W    = 6;
    localparam int P_INTERVAL = 300;
    localparam int CMAX       = (1 << P_CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               acc_valid = 1'b0;
    logic               acc_core = 1'b0;
    logic [P_SET_W-1:0] acc_set = '0;
    logic [P_TAG_W-1:0] acc_tag = '0;
    logic [4:0]         ways_core0;
    logic               partition_valid;

    int n_checks = 0;
    int n_fail   = 0;
    int edge_cnt = 0;
    int n_pulse  = 0;
    int tag_next = 1;
    int last_ways = 8;
    bit done = 1'b0;
    int m_hits [2][16];

    umon_way_partitioner #(
        .SET_W       (P_SET_W),
        .TAG_W       (P_TAG_W),
        .SAMPLE_LOG2 (P_SAMPLE),
        .CNT_W       (P_CNT_W),
        .INTERVAL    (P_INTERVAL)
    ) dut_i (
        .clk             (clk),
        .rst             (rst),
        .acc_valid       (acc_valid),
        .acc_core        (acc_core),
        .acc_set         (acc_set),
        .acc_tag         (acc_tag),
        .ways_core0      (ways_core0),
        .partition_valid (partition_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        if (rst) edge_cnt <= 0;
        else     edge_cnt <= edge_cnt + 1;
    end

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int best_split();
        int best_a = 1;
        int best_t = -1;
        for (int a = 1; a <= 15; a++) begin
            int t = 0;
            for (int i = 0; i < a; i++)      t += m_hits[0][i];
            for (int i = 0; i < 16 - a; i++) t += m_hits[1][i];
            if (t > best_t) begin
                best_t = t;
                best_a = a;
            end
        end
        return best_a;
    endfunction

    task automatic do_acc(input int core, input int set, input int tag);
        acc_valid = 1'b1;
        acc_core  = core[0];
        acc_set   = P_SET_W'(set);
        acc_tag   = P_TAG_W'(tag);
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    // k fresh tags cycled k+n times: n hits at recency position k-1
    task automatic run_hits(input int core, input int set, input int k, input int n);
        int base = tag_next;
        tag_next += k;
        for (int j = 0; j < k + n; j++) do_acc(core, set, base + (j % k));
        if ((set % (1 << P_SAMPLE)) == 0) begin
            m_hits[core][k-1] += n;
            if (m_hits[core][k-1] > CMAX) m_hits[core][k-1] = CMAX;
        end
    endtask

    // both cores interleaved on the same two tags of one set
    task automatic run_pair(input int set, input int n);
        int base = tag_next;
        tag_next += 2;
        for (int j = 0; j < 2 + n; j++) begin
            do_acc(0, set, base + (j % 2));
            do_acc(1, set, base + (j % 2));
        end
        for (int c = 0; c < 2; c++) begin
            m_hits[c][1] += n;
            if (m_hits[c][1] > CMAX) m_hits[c][1] = CMAX;
        end
    endtask

    task automatic check_hold();
        check_eq("R9", "ways held between results", int'(ways_core0), last_ways);
    endtask

    task automatic wait_result(input string req);
        int exp_edge;
        int exp_ways;
        exp_edge = P_INTERVAL + 15 + n_pulse * P_INTERVAL;
        while (!partition_valid && !done) @(negedge clk);
        if (done) return;
        exp_ways = best_split();
        check_eq("R2", "pulse edge", edge_cnt, exp_edge);
        check_eq(req, "ways_core0 result", int'(ways_core0), exp_ways);
        @(negedge clk);
        check_eq("R2", "pulse lasts one cycle", int'(partition_valid), 0);
        check_eq("R9", "ways after pulse", int'(ways_core0), exp_ways);
        last_ways = exp_ways;
        // R7: halve the model at each result
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 16; i++) m_hits[c][i] = m_hits[c][i] / 2;
        n_pulse++;
    endtask

    initial begin
        for (int c = 0; c < 2; c++)
            for (int i = 0; i < 16; i++) m_hits[c][i] = 0;
        repeat (3) @(negedge clk);
        check_eq("R1", "ways in reset", int'(ways_core0), 8);
        check_eq("R1", "valid in reset", int'(partition_valid), 0);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R1", "ways after release", int'(ways_core0), 8);
        check_eq("R1", "valid after release", int'(partition_valid), 0);

        // all counters zero: every split ties, smallest a
        wait_result("R6");

        run_hits(0, 0, 3, 8);
        run_hits(1, 32, 10, 5);
        check_hold();
        wait_result("R5");

        // unsampled set 5 must not count
        run_hits(0, 5, 12, 20);
        run_hits(1, 64, 1, 3);
        check_hold();
        wait_result("R3");

        run_hits(1, 96, 15, 10);
        check_hold();
        wait_result("R5");

        // old core-1 history must lose weight
        run_hits(0, 128, 3, 6);
        check_hold();
        wait_result("R7");

        // core 0 counter saturates at its maximum
        run_hits(0, 160, 14, 70);
        run_hits(1, 192, 5, 50);
        check_hold();
        wait_result("R8");

        // upper bound of the split
        run_hits(0, 224, 15, 30);
        check_hold();
        wait_result("R5");

        // per-core directories with interleaved accesses
        run_pair(0, 10);
        check_hold();
        wait_result("R4");

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule